// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block decides how two unsigned words relate and drives three flags: greater, less and equal. It is built from a 4-bit comparator slice. Each slice has three cascade inputs that carry the verdict of the less significant part of the word. A slice weighs its own bits from the top bit down. The first bit position where the two words differ settles the verdict. The cascade inputs count only when all of the slice's own bits match.

The top module chains WIDTH/4 slices in series. Each slice's three flags feed the cascade inputs of the next more significant slice. The lowest slice has its cascade inputs tied to "equal". The words may be plain binary, BCD or any other code whose order follows its binary value.

On a tie, the slice treats its cascade inputs as a fixed truth table, and that table also defines the outputs for cascade patterns that are not one-hot. This lets the slice serve in feed-forward arrangements as well as in a plain chain.

Top module: `mag_cmp_chain`

## Requirements
- R1: When the words differ and the most significant differing bit is 1 in A, the outputs are greater=1, less=0, equal=0.
- R2: When the words differ and the most significant differing bit is 1 in B, the outputs are greater=0, less=1, equal=0.
- R3: When a slice's words differ, its cascade inputs have no effect on any of its three outputs, whatever their pattern.
- R4: When a slice's words are equal and its cascade equal input is 1, the slice drives equal=1, greater=0, less=0, whatever its cascade greater and less inputs are.
- R5: When a slice's words are equal and exactly one of its cascade greater or less inputs is 1, with cascade equal 0, the slice passes that flag through and drives the other two outputs low.
- R6: When a slice's words are equal and its cascade inputs are greater=1, less=1, equal=0, all three of its outputs are 0.
- R7: When a slice's words are equal and all three of its cascade inputs are 0, the slice drives greater=1, less=1, equal=0.
- R8: The top chains WIDTH/4 slices, where WIDTH is a multiple of 4. Its lowest slice sees greater=0, less=0, equal=1 on its cascade inputs. Its outputs equal (A>B, A<B, A==B) for any pair of WIDTH-bit words.
- R9: Whenever a slice's cascade inputs are one-hot, exactly one of its three outputs is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Word A, unsigned, bit WIDTH-1 most significant |
| b_i | input | WIDTH | Word B, unsigned, bit WIDTH-1 most significant |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |

## Verification
The block is purely combinational, so a wrong decision shows on the flags as soon as the inputs settle, in the same cycle the stimulus is applied. A fault in the priority order shows as a wrong verdict when the words differ in both a high and a low bit. A broken link between slices shows when only the lowest slice's bits differ. A mistake in the tie table shows up only when the cascade patterns are driven directly on a single slice, so all eight patterns are applied there, both with equal words and with differing words.

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          casc_gt_i,
  input  logic          casc_lt_i,
  input  logic          casc_eq_i,
  output logic          gt_o,
  output logic          lt_o,
  output logic          eq_o
);
  logic hi_gt, hi_lt, tie;

  always_comb begin
    hi_gt = 1'b0;
    hi_lt = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!hi_gt && !hi_lt) begin
        hi_gt = a_i[i] & ~b_i[i];
        hi_lt = ~a_i[i] & b_i[i];
      end
    end
  end

  assign tie  = ~(hi_gt | hi_lt);
  assign gt_o = hi_gt | (tie & ~casc_lt_i & ~casc_eq_i);
  assign lt_o = hi_lt | (tie & ~casc_gt_i & ~casc_eq_i);
  assign eq_o = tie & casc_eq_i;

  always_comb begin
    if (a_i > b_i) AST_WORD_GT: assert ({gt_o, lt_o, eq_o} == 3'b100); // R1
    if (a_i < b_i) AST_WORD_LT: assert ({gt_o, lt_o, eq_o} == 3'b010); // R2
    if (eq_o) AST_EQ_NEEDS_TIE: assert (a_i == b_i); // R4
    if (a_i == b_i && casc_eq_i) AST_TIE_EQ: assert ({gt_o, lt_o} == 2'b00); // R4
    if (a_i == b_i && {casc_gt_i, casc_lt_i, casc_eq_i} == 3'b110)
      AST_TIE_BOTH: assert ({gt_o, lt_o, eq_o} == 3'b000); // R6
    if (a_i == b_i && {casc_gt_i, casc_lt_i, casc_eq_i} == 3'b000)
      AST_TIE_NONE: assert ({gt_o, lt_o, eq_o} == 3'b110); // R7
    if ($onehot({casc_gt_i, casc_lt_i, casc_eq_i}))
      AST_ONEHOT_OUT: assert ($onehot({gt_o, lt_o, eq_o})); // R9
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain #(
  parameter int WIDTH = 12,
  parameter int SW    = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam int NS = WIDTH / SW;

  logic [NS:0] c_gt, c_lt, c_eq;

  assign c_gt[0] = 1'b0;
  assign c_lt[0] = 1'b0;
  assign c_eq[0] = 1'b1;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    mag_cmp_slice #(.SW(SW)) u_slice (
      .a_i      (a_i[k*SW +: SW]),
      .b_i      (b_i[k*SW +: SW]),
      .casc_gt_i(c_gt[k]),
      .casc_lt_i(c_lt[k]),
      .casc_eq_i(c_eq[k]),
      .gt_o     (c_gt[k+1]),
      .lt_o     (c_lt[k+1]),
      .eq_o     (c_eq[k+1])
    );
  end

  assign gt_o = c_gt[NS];
  assign lt_o = c_lt[NS];
  assign eq_o = c_eq[NS];

  initial AST_WIDTH_MULT: assert (WIDTH % SW == 0 && WIDTH >= SW); // R8

  always_comb begin
    AST_WIDE_MATCH: assert ({gt_o, lt_o, eq_o} == {a_i > b_i, a_i < b_i, a_i == b_i}); // R8
  end
endmodule

// File: tb/mag_cmp_chain_test.sv
module mag_cmp_chain_test;
  localparam int W  = 12;
  localparam int NV = 10;
  // {a, b, expected gt lt eq}
  localparam logic [2*W+2:0] VEC [NV] = '{
    {12'h000, 12'h000, 3'b001},
    {12'hFFF, 12'hFFF, 3'b001},
    {12'h800, 12'h7FF, 3'b100},
    {12'h7FF, 12'h800, 3'b010},
    {12'h123, 12'h124, 3'b010},
    {12'hA50, 12'hA4F, 3'b100},
    {12'h0F0, 12'h0F0, 3'b001},
    {12'h001, 12'h000, 3'b100},
    {12'h999, 12'h998, 3'b100},
    {12'h450, 12'h451, 3'b010}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic gt, lt, eq;
  logic [3:0] sa = '0, sb = '0;
  logic [2:0] sc = 3'b001;
  logic sgt, slt, seq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  mag_cmp_chain #(.WIDTH(W)) uut (.a_i(a), .b_i(b), .gt_o(gt), .lt_o(lt), .eq_o(eq));
  mag_cmp_slice #(.SW(4)) one (.a_i(sa), .b_i(sb), .casc_gt_i(sc[2]), .casc_lt_i(sc[1]),
                               .casc_eq_i(sc[0]), .gt_o(sgt), .lt_o(slt), .eq_o(seq));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wide(input logic [W-1:0] va, input logic [W-1:0] vb, input logic [2:0] exp,
                      input string req);
    @(posedge clk); #1;
    a = va; b = vb;
    @(negedge clk);
    check(req, {gt, lt, eq}, exp);
  endtask

  function automatic logic [2:0] tie_rule(input logic [2:0] c);
    if (c[0]) return 3'b001;              // R4
    case (c[2:1])
      2'b10:   return 3'b100;             // R5
      2'b01:   return 3'b010;             // R5
      2'b11:   return 3'b000;             // R6
      default: return 3'b110;             // R7
    endcase
  endfunction

  initial begin
    @(negedge clk);
    check("R8 idle", {gt, lt, eq}, 3'b001);
    for (int i = 0; i < NV; i++)
      wide(VEC[i][2*W+2 -: W], VEC[i][W+2 -: W], VEC[i][2:0], "R8 table");
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (i % 4 == 0) ? ra ^ W'(1 << (i % W)) : W'($urandom);
      if (i % 7 == 0) rb = ra;
      wide(ra, rb, {ra > rb, ra < rb, ra == rb},
           ra > rb ? "R1" : (ra < rb ? "R2" : "R8"));
    end
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1;
      sa = 4'h6; sb = 4'h6; sc = 3'(c);
      @(negedge clk);
      check("R4 R5 R6 R7 tie", {sgt, slt, seq}, tie_rule(3'(c)));
      if ($onehot(3'(c))) check("R9 onehot", {2'b00, $onehot({sgt, slt, seq})}, 3'b001);
      @(posedge clk); #1;
      sa = 4'h8; sb = 4'h7;
      @(negedge clk);
      check("R3 gt ignores cascade", {sgt, slt, seq}, 3'b100);
      @(posedge clk); #1;
      sa = 4'h2; sb = 4'h3;
      @(negedge clk);
      check("R3 lt ignores cascade", {sgt, slt, seq}, 3'b010);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule